// File: doc/BRIEF.md
# Width-Adaptive Lane-to-Flit Gearbox

This receive-side block turns the per-cycle lane samples of a 20-lane point-to-point link into 80-bit flow-control units. The link may be trained to run on all 20 lanes, on two 5-lane quadrants (10 bits per transfer) or on a single quadrant (5 bits per transfer). The flit size stays fixed at 80 bits, so the block collects 4, 8 or 16 transfers per flit. Transfers are packed from the least significant bit upward. When the last transfer of a flit arrives, the block presents the whole flit with a one-cycle valid pulse.

During link bring-up the transmitter sends a fixed 20-bit training word. From that word alone the receiver works out two things. It learns whether the board wiring has reversed the whole lane order. It also learns which individual lanes have their differential pair swapped, which inverts those lanes. From then on it corrects every transfer, so no strap or configuration register is needed. The width mode comes from link initialization. A per-quadrant good mask selects which quadrants carry data in the reduced widths.

Top module: `flit_gearbox`

## Requirements
- R1: While reset is asserted and after it is released, `flit_vld` is 0 and `flit_data` is 0. Until a training word is seen, lanes are taken in their physical order with no inversion, so the four full-width transfers w0..w3 give the flit {w3,w2,w1,w0}.
- R2: With `width_sel`=0 (full width), each transfer holds 20 bits, and transfer k fills flit bits [20k+19:20k]. `flit_vld` is high for exactly the one cycle after the clock edge that accepts the 4th transfer, and in that same cycle `flit_data` carries the new flit. `flit_data` holds its value until the next flit.
- R3: With `width_sel`=1 (half width), 8 transfers of 10 bits make one flit, and transfer k fills bits [10k+9:10k]. The 10 bits come from the two lowest-numbered quadrants marked good. Quadrant q is logical lanes 5q..5q+4 and is marked by `good_quad[q]`. The lower-numbered of the two quadrants gives the low 5 bits.
- R4: With `width_sel`=2 or 3 (quarter width), 16 transfers of 5 bits make one flit, taken from the lowest-numbered quadrant marked good. Transfer k fills bits [5k+4:5k].
- R5: A transfer with both `lane_vld` and `train_en` high is compared with the training word 20'hA5C3F, both as received and bit-reversed. Lane reversal is declared when the bit-reversed compare has strictly fewer mismatching lanes. From then on, physical lane i is read as logical lane 19-i.
- R6: For the same training transfer, every logical lane that mismatches in the chosen orientation is marked inverted. All later transfers have those lanes complemented.
- R7: A training transfer is never packed into a flit, and it restarts flit assembly from transfer 0.
- R8: In any cycle where `width_sel` differs from its value in the previous cycle, a transfer offered in that cycle is dropped and any partly assembled flit is discarded. The next accepted transfer is transfer 0.
- R9: A cycle with `lane_vld` low neither advances assembly nor produces a flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one transfer per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_in | input | 20 | Raw lane bits in physical lane order |
| lane_vld | input | 1 | Transfer present on `lane_in` this cycle |
| train_en | input | 1 | Transfer is the training word |
| width_sel | input | 2 | 0 full, 1 half, 2 or 3 quarter width |
| good_quad | input | 4 | Usable quadrant mask, bit q for lanes 5q..5q+4 |
| flit_data | output | 80 | Last assembled flit |
| flit_vld | output | 1 | One-cycle pulse marking a new flit |

## Verification
The hardest situations to reach from the ports are the ones where stale state could leak into a new flit. One is a width change in the middle of a flit. Another is a training word arriving after part of a flit has been collected. The stimulus reaches both by sending a few transfers in one mode, then either switching `width_sel` in the same cycle as a junk transfer or inserting a training word. It then checks that the flit appears only after the full transfer count of the new context and carries exactly the new payload. Each orientation case is driven by encoding the payload through a chosen reversal and inversion mask on the bench side. Non-adjacent good quadrants are also covered, so that every correction path and every quadrant choice must be undone by the block.

// File: rtl/gb_pkg.sv
package gb_pkg;
  localparam int LANES     = 20;
  localparam int QW        = 5;
  localparam int NQ        = LANES / QW;
  localparam int QI_W      = $clog2(NQ);
  localparam int HALF_W    = 2 * QW;
  localparam int FLIT_W    = 80;
  localparam int MAX_BEATS = FLIT_W / QW;
  localparam int CNT_W     = $clog2(MAX_BEATS);
  localparam int LIM_W     = CNT_W + 1;
  localparam logic [LANES-1:0] TRAIN_WORD = 20'hA5C3F;

  typedef enum logic [1:0] {
    WM_FULL = 2'd0,
    WM_HALF = 2'd1,
    WM_QTR  = 2'd2,
    WM_QTR2 = 2'd3
  } wmode_e;

  function automatic int popcnt(input logic [LANES-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < LANES; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/gb_orient.sv
module gb_orient
  import gb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] raw,
  input  logic             train_stb,
  output logic [LANES-1:0] logical
);
  logic [LANES-1:0] flip;
  logic [LANES-1:0] diff_str, diff_rev;
  logic             rev_n, rev_q;
  logic [LANES-1:0] inv_n, inv_q;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_flip
      assign flip[i] = raw[LANES-1-i];
    end
  endgenerate

  always_comb begin
    diff_str = raw ^ TRAIN_WORD;
    diff_rev = flip ^ TRAIN_WORD;
    rev_n    = popcnt(diff_rev) < popcnt(diff_str);
    inv_n    = rev_n ? diff_rev : diff_str;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_q <= 1'b0;
      inv_q <= '0;
    end else if (train_stb) begin
      rev_q <= rev_n;
      inv_q <= inv_n;
    end
  end

  assign logical = (rev_q ? flip : raw) ^ inv_q;
endmodule

// File: rtl/gb_quad_sel.sv
module gb_quad_sel
  import gb_pkg::*;
(
  input  logic [LANES-1:0] logical,
  input  logic [1:0]       width_sel,
  input  logic [NQ-1:0]    good_quad,
  output logic [LANES-1:0] chunk,
  output logic [LIM_W-1:0] beat_lim
);
  logic [QW-1:0]   quad [NQ];
  logic [QI_W-1:0] f0, f1;
  int              found;

  generate
    for (genvar q = 0; q < NQ; q++) begin : g_quad
      assign quad[q] = logical[q*QW +: QW];
    end
  endgenerate

  always_comb begin
    f0    = '0;
    f1    = '0;
    found = 0;
    for (int q = 0; q < NQ; q++) begin
      if (good_quad[q]) begin
        if (found == 0) f0 = QI_W'(q);
        else if (found == 1) f1 = QI_W'(q);
        found = found + 1;
      end
    end
  end

  always_comb begin
    chunk = '0;
    case (wmode_e'(width_sel))
      WM_FULL: begin
        chunk    = logical;
        beat_lim = LIM_W'(FLIT_W / LANES);
      end
      WM_HALF: begin
        chunk[QW-1:0]      = quad[f0];
        chunk[HALF_W-1:QW] = quad[f1];
        beat_lim           = LIM_W'(FLIT_W / HALF_W);
      end
      default: begin
        chunk[QW-1:0] = quad[f0];
        beat_lim      = LIM_W'(FLIT_W / QW);
      end
    endcase
  end
endmodule

// File: rtl/gb_assembler.sv
module gb_assembler
  import gb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  chunk,
  input  logic [1:0]        width_sel,
  input  logic [LIM_W-1:0]  beat_lim,
  input  logic              take,
  input  logic              clr,
  output logic [FLIT_W-1:0] flit_data,
  output logic              flit_vld,
  output logic [CNT_W-1:0]  xfer_cnt
);
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [FLIT_W-1:0] sr_q, sr_n;
  logic [FLIT_W-1:0] out_q, out_n;
  logic              vld_q, vld_n;
  logic              last;

  always_comb begin
    cnt_n = cnt_q;
    sr_n  = sr_q;
    out_n = out_q;
    vld_n = 1'b0;
    last  = ({1'b0, cnt_q} == beat_lim - 1'b1);
    if (clr) begin
      cnt_n = '0;
    end else if (take) begin
      case (wmode_e'(width_sel))
        WM_FULL: sr_n[cnt_q*LANES +: LANES]   = chunk;
        WM_HALF: sr_n[cnt_q*HALF_W +: HALF_W] = chunk[HALF_W-1:0];
        default: sr_n[cnt_q*QW +: QW]         = chunk[QW-1:0];
      endcase
      if (last) begin
        cnt_n = '0;
        vld_n = 1'b1;
        out_n = sr_n;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_n;
      if (clr || take) cnt_q <= cnt_n;
      if (take) sr_q <= sr_n;
      if (vld_n) out_q <= out_n;
    end
  end

  assign flit_data = out_q;
  assign flit_vld  = vld_q;
  assign xfer_cnt  = cnt_q;
endmodule

// File: rtl/flit_gearbox.sv
module flit_gearbox
  import gb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] lane_in,
  input  logic        lane_vld,
  input  logic        train_en,
  input  logic [1:0]  width_sel,
  input  logic [3:0]  good_quad,
  output logic [79:0] flit_data,
  output logic        flit_vld
);
  logic [1:0]       mode_q;
  logic             chg;
  logic             train_stb;
  logic             take;
  logic             clr;
  logic [LANES-1:0] logical;
  logic [LANES-1:0] chunk;
  logic [LIM_W-1:0] beat_lim;
  logic [CNT_W-1:0] xfer_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 2'd0;
    else        mode_q <= width_sel;
  end

  always_comb begin
    chg       = (width_sel != mode_q);
    train_stb = lane_vld & train_en;
    take      = lane_vld & ~train_en & ~chg;
    clr       = chg | train_stb;
  end

  gb_orient u_orient (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw       (lane_in),
    .train_stb (train_stb),
    .logical   (logical)
  );

  gb_quad_sel u_qsel (
    .logical   (logical),
    .width_sel (width_sel),
    .good_quad (good_quad),
    .chunk     (chunk),
    .beat_lim  (beat_lim)
  );

  gb_assembler u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .chunk     (chunk),
    .width_sel (width_sel),
    .beat_lim  (beat_lim),
    .take      (take),
    .clr       (clr),
    .flit_data (flit_data),
    .flit_vld  (flit_vld),
    .xfer_cnt  (xfer_cnt)
  );
endmodule

// File: rtl/gb_checker.sv
module gb_checker
  import gb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             lane_vld,
  input logic             train_en,
  input logic [1:0]       width_sel,
  input logic [1:0]       mode_q,
  input logic             flit_vld,
  input logic [CNT_W-1:0] xfer_cnt,
  input logic [LIM_W-1:0] beat_lim
);
  AST_FLIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flit_vld |=> !flit_vld); // R2

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (width_sel == mode_q) |-> ({1'b0, xfer_cnt} < beat_lim)); // R3

  AST_TRAIN_NO_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_vld && train_en) |=> !flit_vld); // R7

  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (width_sel != $past(width_sel)) |=> !flit_vld); // R8

  AST_IDLE_NO_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_vld |=> !flit_vld); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !flit_vld); // R1
endmodule

bind flit_gearbox gb_checker chk_i (.*);

// File: tb/flit_gearbox_tb_top.sv
module flit_gearbox_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] TRAIN = 20'hA5C3F;
  localparam logic [19:0] JUNK  = 20'h6B3D2;

  typedef struct packed {
    logic [1:0]  mode;
    logic        rev;
    logic [19:0] inv;
    logic [3:0]  good;
    logic [79:0] pay;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 20'h00000, 4'hF,    80'h0123456789ABCDEF0011},
    '{2'd0, 1'b1, 20'h00000, 4'hF,    80'hFEDCBA98765432100F0F},
    '{2'd1, 1'b0, 20'h00421, 4'hF,    80'hA5A55A5A12348765C3C3},
    '{2'd1, 1'b1, 20'h10081, 4'b1010, 80'h13579BDF02468ACE5566},
    '{2'd2, 1'b0, 20'h08000, 4'b0100, 80'hC0FFEE0123BADF00D777},
    '{2'd3, 1'b1, 20'h00006, 4'b1000, 80'h9E3779B97F4A7C15F39C}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] lane_in;
  logic        lane_vld;
  logic        train_en;
  logic [1:0]  width_sel;
  logic [3:0]  good_quad;
  logic [79:0] flit_data;
  logic        flit_vld;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flit_gearbox dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_in   (lane_in),
    .lane_vld  (lane_vld),
    .train_en  (train_en),
    .width_sel (width_sel),
    .good_quad (good_quad),
    .flit_data (flit_data),
    .flit_vld  (flit_vld)
  );

  function automatic logic [19:0] bitrev(input logic [19:0] v);
    logic [19:0] r;
    for (int i = 0; i < 20; i++) r[i] = v[19-i];
    return r;
  endfunction

  function automatic logic [19:0] enc(input logic [19:0] lg, input logic rev,
                                      input logic [19:0] inv);
    logic [19:0] w;
    w = lg ^ inv;
    return rev ? bitrev(w) : w;
  endfunction

  function automatic logic [19:0] beat_word(input logic [79:0] pay, input logic [1:0] mode,
                                            input logic [3:0] good, input int k);
    logic [19:0] lg;
    int f0, f1, n;
    f0 = 0; f1 = 0; n = 0;
    for (int q = 0; q < 4; q++) begin
      if (good[q]) begin
        if (n == 0) f0 = q;
        else if (n == 1) f1 = q;
        n++;
      end
    end
    lg = JUNK;
    if (mode == 2'd0) begin
      lg = pay[k*20 +: 20];
    end else if (mode == 2'd1) begin
      lg[f0*5 +: 5] = pay[k*10 +: 5];
      lg[f1*5 +: 5] = pay[k*10+5 +: 5];
    end else begin
      lg[f0*5 +: 5] = pay[k*5 +: 5];
    end
    return lg;
  endfunction

  function automatic int beats_of(input logic [1:0] mode);
    return (mode == 2'd0) ? 4 : (mode == 2'd1) ? 8 : 16;
  endfunction

  task automatic step(input logic [19:0] raw, input logic v, input logic t,
                      input logic [1:0] mode);
    @(negedge clk);
    lane_in   = raw;
    lane_vld  = v;
    train_en  = t;
    width_sel = mode;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string req,
                     input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [79:0] p;
    logic [19:0] w [4];
    bit early;
    string tag;
    int nb;

    rst_n = 1'b0; lane_in = '0; lane_vld = 1'b0; train_en = 1'b0;
    width_sel = 2'd0; good_quad = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    chk(flit_vld == 1'b0, "R1 vld in reset", 80'(flit_vld), 80'd0);
    chk(flit_data == '0, "R1 data in reset", flit_data, 80'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: untrained path is straight, no inversion
    w[0] = 20'h12345; w[1] = 20'hABCDE; w[2] = 20'h0F0F0; w[3] = 20'h9C3A1;
    for (int k = 0; k < 4; k++) step(w[k], 1'b1, 1'b0, 2'd0);
    chk(flit_vld == 1'b1, "R1 vld untrained", 80'(flit_vld), 80'd1);
    chk(flit_data == {w[3], w[2], w[1], w[0]}, "R1 data untrained", flit_data,
        {w[3], w[2], w[1], w[0]});
    step(20'h0, 1'b0, 1'b0, 2'd0);
    chk(flit_vld == 1'b0, "R2 single-cycle pulse", 80'(flit_vld), 80'd0);
    chk(flit_data == {w[3], w[2], w[1], w[0]}, "R2 data held", flit_data,
        {w[3], w[2], w[1], w[0]});

    // Table of modes, orientations, inversions and quadrant masks
    for (int v = 0; v < NV; v++) begin
      tag = (VECS[v].mode == 2'd0) ? "R2" : (VECS[v].mode == 2'd1) ? "R3" : "R4";
      if (VECS[v].rev) tag = {tag, "/R5"};
      if (VECS[v].inv != '0) tag = {tag, "/R6"};
      good_quad = VECS[v].good;
      nb = beats_of(VECS[v].mode);
      step(20'h0, 1'b0, 1'b0, VECS[v].mode);
      step(enc(TRAIN, VECS[v].rev, VECS[v].inv), 1'b1, 1'b1, VECS[v].mode);
      early = 1'b0;
      for (int k = 0; k < nb; k++) begin
        step(enc(beat_word(VECS[v].pay, VECS[v].mode, VECS[v].good, k),
                 VECS[v].rev, VECS[v].inv), 1'b1, 1'b0, VECS[v].mode);
        if (k < nb - 1 && flit_vld) early = 1'b1;
      end
      chk(!early, {tag, " no early flit"}, 80'(early), 80'd0);
      chk(flit_vld == 1'b1, {tag, " flit valid"}, 80'(flit_vld), 80'd1);
      chk(flit_data == VECS[v].pay, {tag, " flit data"}, flit_data, VECS[v].pay);
    end

    // Retrain straight, full width, all quadrants
    good_quad = 4'hF;
    step(20'h0, 1'b0, 1'b0, 2'd0);
    step(TRAIN, 1'b1, 1'b1, 2'd0);

    // R9: idle gaps between transfers
    p = 80'h5555AAAA3333CCCC0F1E;
    early = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step(p[k*20 +: 20], 1'b1, 1'b0, 2'd0);
      if (k < 3 && flit_vld) early = 1'b1;
      step(20'hFFFFF, 1'b0, 1'b0, 2'd0);
      if (k < 3 && flit_vld) early = 1'b1;
    end
    chk(!early, "R9 idle does not advance", 80'(early), 80'd0);
    chk(flit_data == p, "R9 data across gaps", flit_data, p);

    // R7: training word mid-flit restarts assembly
    step(20'h11111, 1'b1, 1'b0, 2'd0);
    step(20'h22222, 1'b1, 1'b0, 2'd0);
    step(TRAIN, 1'b1, 1'b1, 2'd0);
    chk(flit_vld == 1'b0, "R7 no flit on training", 80'(flit_vld), 80'd0);
    p = 80'h0BADC0DE1234FEEDBEEF;
    early = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step(p[k*20 +: 20], 1'b1, 1'b0, 2'd0);
      if (k < 3 && flit_vld) early = 1'b1;
    end
    chk(!early, "R7 count restarted", 80'(early), 80'd0);
    chk(flit_vld == 1'b1, "R7 flit valid", 80'(flit_vld), 80'd1);
    chk(flit_data == p, "R7 flit data", flit_data, p);

    // R8: width change mid-flit, transfer in change cycle dropped
    step(20'h33333, 1'b1, 1'b0, 2'd0);
    step(20'h44444, 1'b1, 1'b0, 2'd0);
    step(20'h77777, 1'b1, 1'b0, 2'd1);
    chk(flit_vld == 1'b0, "R8 no flit on change", 80'(flit_vld), 80'd0);
    p = 80'hDEADBEEF0123456789AB;
    early = 1'b0;
    for (int k = 0; k < 8; k++) begin
      step(beat_word(p, 2'd1, 4'hF, k), 1'b1, 1'b0, 2'd1);
      if (k < 7 && flit_vld) early = 1'b1;
    end
    chk(!early, "R8 partial flit flushed", 80'(early), 80'd0);
    chk(flit_vld == 1'b1, "R8 flit valid", 80'(flit_vld), 80'd1);
    chk(flit_data == p, "R8 flit data", flit_data, p);

    step(20'h0, 1'b0, 1'b0, 2'd1);
    finish_run();
  end
endmodule